// File: doc/BRIEF.md
# Packet Timestamp Capture Registers

This block keeps one timestamp latch for received packets and one for transmitted packets. A packet parser elsewhere raises a single-cycle strobe when a packet that needs a stamp goes by. If that direction is switched on and holds no unread stamp, the block copies the free-running time input into the direction's 64-bit latch and raises its valid flag. From then on the direction is locked. Later strobes are dropped and counted, so the stored stamp is certain to belong to the one packet that set it.

Software uses a small word-wide register port. It polls the valid flag, reads the low half and then the high half of the stamp, and builds the 64-bit value itself. The high-half read releases the lock and re-arms capture. Software can also clear any stale stamp by reading both halves of each direction after configuration, or by switching the direction off. The time counter, the packet parsing and data movement all live outside this block.

Top module: `pkt_stamp_capture`

## Requirements
- R1: After reset both enables and both valid flags are 0, both stamps and both drop counts are 0, and `reg_rdata` is 0.
- R2: When a direction is enabled and not valid, and no high-half read of that direction occurs in the same cycle, its strobe stores the `time_now` value of that cycle and sets the valid flag on the next edge.
- R3: While a direction is valid, its strobes leave the stored stamp unchanged.
- R4: A read at offset 1 (receive) or 5 (transmit) returns stamp bits 31:0. A read at offset 2 or 6 returns bits 63:32. `reg_rdata` takes the value on the clock edge that samples `reg_rd` and holds it until the next read.
- R5: A high-half read clears that direction's valid flag on the edge that samples it, which re-arms capture. A low-half read leaves the flag set.
- R6: A strobe in the same cycle as a high-half read of its own direction is ignored, even when the flag was already clear.
- R7: While a direction's enable is 0, its strobes do not set valid and do not change the stamp.
- R8: Each ignored strobe (locked, disabled, or hit by a same-cycle high read) adds one to that direction's drop count, which is read at offset 3 (receive) or 7 (transmit). The count saturates at its all-ones value.
- R9: Writing 0 to a direction's enable clears its valid flag, so the next strobe after it is enabled again is captured.
- R10: The two directions are independent. A strobe, write or read aimed at one leaves the other's flag, stamp and count unchanged.
- R11: The control register sits at offset 0 (receive) and 4 (transmit). Bit 0 is the enable (read/write), bit 1 is the valid flag (read-only), and all other bits read 0. `reg_addr` bit 2 selects the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_event | input | 1 | Single-cycle receive stamp strobe |
| tx_event | input | 1 | Single-cycle transmit stamp strobe |
| time_now | input | 2*WORD_W | Current time from the time counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Registered read data |

## Verification
The checker assumes that the strobes and the register strobes are clean single-cycle pulses, sampled on the rising edge, and that `time_now` is stable around that edge. It also assumes that no control write switches a direction off in the same cycle as that direction's strobe. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It never combines a disabling write with a strobe. Where it does combine events, the combination is a strobe with a same-cycle high-half read, which is the case R6 defines.

// File: rtl/stamp_cap_pkg.sv
package stamp_cap_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_LANES = 2;
  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_VALID_BIT = 1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_DROP = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stamp_lane.sv
module stamp_lane #(
  parameter int TIME_W = 64,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              en_wdata,
  input  logic              hi_rd,
  input  logic              strobe,
  input  logic [TIME_W-1:0] time_in,
  output logic              enable,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic [DROP_W-1:0] drops
);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic capture;
  logic dropped;

  // capture only when armed and not colliding with the releasing read
  assign capture = strobe & enable & ~valid & ~hi_rd;
  assign dropped = strobe & ~capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
    end else if (ctrl_wr) begin
      enable <= en_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (ctrl_wr && !en_wdata) begin
      valid <= 1'b0;
    end else if (hi_rd) begin
      valid <= 1'b0;
    end else if (capture) begin
      valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp <= '0;
    end else if (capture && !(ctrl_wr && !en_wdata)) begin
      stamp <= time_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drops <= '0;
    end else if ((dropped || (capture && ctrl_wr && !en_wdata)) && drops != DROP_MAX) begin
      drops <= drops + 1'b1;
    end
  end
endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import stamp_cap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DROP_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 reg_wr,
  input  logic                                 reg_rd,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic [NUM_LANES-1:0]                 lane_en,
  input  logic [NUM_LANES-1:0]                 lane_valid,
  input  logic [NUM_LANES-1:0][2*WORD_W-1:0]   lane_stamp,
  input  logic [NUM_LANES-1:0][DROP_W-1:0]     lane_drops,
  output logic [NUM_LANES-1:0]                 ctrl_wr,
  output logic [NUM_LANES-1:0]                 hi_rd,
  output logic [WORD_W-1:0]                    reg_rdata
);
  reg_sel_e   sel;
  logic       lane_sel;
  logic [WORD_W-1:0] rd_mux;

  assign sel      = reg_sel_e'(reg_addr[1:0]);
  assign lane_sel = reg_addr[ADDR_W-1];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
    assign ctrl_wr[g] = reg_wr && (lane_sel == 1'(g)) && (sel == SEL_CTRL);
    assign hi_rd[g]   = reg_rd && (lane_sel == 1'(g)) && (sel == SEL_HI);
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_mux[CTRL_EN_BIT]    = lane_en[lane_sel];
        rd_mux[CTRL_VALID_BIT] = lane_valid[lane_sel];
      end
      SEL_LO:   rd_mux = lane_stamp[lane_sel][WORD_W-1:0];
      SEL_HI:   rd_mux = lane_stamp[lane_sel][2*WORD_W-1:WORD_W];
      SEL_DROP: rd_mux[DROP_W-1:0] = lane_drops[lane_sel];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pkt_stamp_capture.sv
module pkt_stamp_capture
  import stamp_cap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DROP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_event,
  input  logic                tx_event,
  input  logic [2*WORD_W-1:0] time_now,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata
);
  localparam int TIME_W = 2 * WORD_W;

  logic [NUM_LANES-1:0]               strobes;
  logic [NUM_LANES-1:0]               ctrl_wr;
  logic [NUM_LANES-1:0]               hi_rd;
  logic [NUM_LANES-1:0]               lane_en;
  logic [NUM_LANES-1:0]               lane_valid;
  logic [NUM_LANES-1:0][TIME_W-1:0]   lane_stamp;
  logic [NUM_LANES-1:0][DROP_W-1:0]   lane_drops;

  assign strobes[LANE_RX] = rx_event;
  assign strobes[LANE_TX] = tx_event;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    stamp_lane #(
      .TIME_W (TIME_W),
      .DROP_W (DROP_W)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ctrl_wr  (ctrl_wr[g]),
      .en_wdata (reg_wdata[CTRL_EN_BIT]),
      .hi_rd    (hi_rd[g]),
      .strobe   (strobes[g]),
      .time_in  (time_now),
      .enable   (lane_en[g]),
      .valid    (lane_valid[g]),
      .stamp    (lane_stamp[g]),
      .drops    (lane_drops[g])
    );
  end

  stamp_regs #(
    .WORD_W (WORD_W),
    .DROP_W (DROP_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .lane_en    (lane_en),
    .lane_valid (lane_valid),
    .lane_stamp (lane_stamp),
    .lane_drops (lane_drops),
    .ctrl_wr    (ctrl_wr),
    .hi_rd      (hi_rd),
    .reg_rdata  (reg_rdata)
  );
endmodule

// File: rtl/pkt_stamp_capture_chk.sv
module pkt_stamp_capture_chk #(
  parameter int WORD_W = 32,
  parameter int DROP_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rx_event,
  input logic                     tx_event,
  input logic [2*WORD_W-1:0]      time_now,
  input logic                     reg_wr,
  input logic                     reg_rd,
  input logic [2:0]               reg_addr,
  input logic [WORD_W-1:0]        reg_wdata,
  input logic [1:0]               lane_en,
  input logic [1:0]               lane_valid,
  input logic [1:0][2*WORD_W-1:0] lane_stamp,
  input logic [1:0][DROP_W-1:0]   lane_drops
);
  logic rx_hi_read, tx_hi_read, rx_ctrl_wr, tx_ctrl_wr;
  assign rx_hi_read = reg_rd && reg_addr == 3'd2;
  assign tx_hi_read = reg_rd && reg_addr == 3'd6;
  assign rx_ctrl_wr = reg_wr && reg_addr == 3'd0;
  assign tx_ctrl_wr = reg_wr && reg_addr == 3'd4;

  a_r2_rx_capture: assert property (@(posedge clk) disable iff (rst)
    (rx_event && lane_en[0] && !lane_valid[0] && !rx_hi_read && !rx_ctrl_wr)
      |=> (lane_valid[0] && lane_stamp[0] == $past(time_now)));

  a_r3_rx_locked_stable: assert property (@(posedge clk) disable iff (rst)
    lane_valid[0] |=> $stable(lane_stamp[0]));

  a_r3_tx_locked_stable: assert property (@(posedge clk) disable iff (rst)
    lane_valid[1] |=> $stable(lane_stamp[1]));

  a_r5_rx_hi_clears: assert property (@(posedge clk) disable iff (rst)
    rx_hi_read |=> !lane_valid[0]);

  a_r6_tx_hi_blocks: assert property (@(posedge clk) disable iff (rst)
    (tx_hi_read && tx_event) |=> !lane_valid[1]);

  a_r9_valid_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !lane_en[0] |-> !lane_valid[0]);

  a_r8_rx_drop_count: assert property (@(posedge clk) disable iff (rst)
    (rx_event && !rx_ctrl_wr && (!lane_en[0] || lane_valid[0])
      && lane_drops[0] != {DROP_W{1'b1}})
      |=> lane_drops[0] == $past(lane_drops[0]) + 1'b1);

  a_r10_tx_untouched_by_rx: assert property (@(posedge clk) disable iff (rst)
    (!tx_event && !tx_ctrl_wr && !tx_hi_read) |=> $stable(lane_valid[1]));
endmodule

bind pkt_stamp_capture pkt_stamp_capture_chk #(
  .WORD_W (WORD_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_event   (rx_event),
  .tx_event   (tx_event),
  .time_now   (time_now),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .lane_en    (lane_en),
  .lane_valid (lane_valid),
  .lane_stamp (lane_stamp),
  .lane_drops (lane_drops)
);

// File: tb/pkt_stamp_capture_test.sv
module pkt_stamp_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int DROP_W = 4;
  localparam int WATCHDOG_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_event = 1'b0;
  logic              tx_event = 1'b0;
  logic [63:0]       time_now = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rx_drops_exp = 0;
  int tx_drops_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_stamp_capture #(.WORD_W(WORD_W), .DROP_W(DROP_W)) uut (
    .clk(clk), .rst(rst), .rx_event(rx_event), .tx_event(tx_event),
    .time_now(time_now), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit tx, input logic [63:0] t);
    @(negedge clk);
    time_now = t;
    if (tx) tx_event = 1'b1; else rx_event = 1'b1;
    @(negedge clk);
    rx_event = 1'b0; tx_event = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register zero after reset", d, 32'h0);
    end
  endtask

  task automatic t_capture_rx();
    logic [31:0] d;
    logic [63:0] ta = 64'h1122_3344_5566_7788;
    wr(3'd0, 32'hFFFF_FFF1);
    rd(3'd0, d); chk("R11 enable only reads back bit0", d, 32'h1);
    pulse(1'b0, ta);
    rd(3'd0, d); chk("R2 rx valid set", d, 32'h3);
    rd(3'd1, d); chk("R4 rx low word", d, ta[31:0]);
    rd(3'd2, d); chk("R4 rx high word", d, ta[63:32]);
    rd(3'd0, d); chk("R5 high read clears valid", d, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    logic [63:0] tb_ = 64'hAAAA_0001_BBBB_0002;
    pulse(1'b0, tb_);
    pulse(1'b0, 64'hDEAD_BEEF_CAFE_F00D);
    rx_drops_exp++;
    rd(3'd1, d); chk("R3 locked stamp low kept", d, tb_[31:0]);
    rd(3'd0, d); chk("R5 low read keeps valid", d, 32'h3);
    rd(3'd3, d); chk("R8 rx drop after locked strobe", d, 32'(rx_drops_exp));
    rd(3'd2, d); chk("R3 locked stamp high kept", d, tb_[63:32]);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd2; rx_event = 1'b1;
    time_now = 64'h0F0F_0F0F_F0F0_F0F0;
    @(negedge clk);
    reg_rd = 1'b0; rx_event = 1'b0;
    rx_drops_exp++;
    rd(3'd0, d); chk("R6 same-cycle strobe ignored", d, 32'h1);
    rd(3'd1, d); chk("R6 stamp untouched", d, 32'hBBBB_0002);
    rd(3'd3, d); chk("R8 same-cycle strobe counted", d, 32'(rx_drops_exp));
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(3'd0, 32'h0);
    pulse(1'b0, 64'h5555_5555_5555_5555);
    rx_drops_exp++;
    rd(3'd0, d); chk("R7 disabled no valid", d, 32'h0);
    rd(3'd1, d); chk("R7 disabled stamp kept", d, 32'hBBBB_0002);
    rd(3'd3, d); chk("R8 disabled strobe counted", d, 32'(rx_drops_exp));
  endtask

  task automatic t_disable_clears();
    logic [31:0] d;
    logic [63:0] tf = 64'h0000_0042_0000_0099;
    wr(3'd0, 32'h1);
    pulse(1'b0, 64'h7777_0000_7777_0000);
    rd(3'd0, d); chk("R2 captured before disable", d, 32'h3);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R9 disable clears valid", d, 32'h0);
    wr(3'd0, 32'h1);
    pulse(1'b0, tf);
    rd(3'd1, d); chk("R9 recaptured low", d, tf[31:0]);
    rd(3'd2, d); chk("R9 recaptured high", d, tf[63:32]);
  endtask

  task automatic t_tx_indep();
    logic [31:0] d;
    logic [63:0] tg = 64'h1357_9BDF_2468_ACE0;
    wr(3'd4, 32'h1);
    pulse(1'b1, tg);
    rd(3'd4, d); chk("R10 tx valid", d, 32'h3);
    rd(3'd0, d); chk("R10 rx ctrl unaffected", d, 32'h1);
    rd(3'd1, d); chk("R10 rx stamp unaffected", d, 32'h0000_0099);
    rd(3'd5, d); chk("R4 tx low word", d, tg[31:0]);
    rd(3'd3, d); chk("R10 rx drops unaffected", d, 32'(rx_drops_exp));
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    for (int i = 0; i < 20; i++) begin
      pulse(1'b1, 64'(i));
      if (tx_drops_exp < 15) tx_drops_exp++;
    end
    rd(3'd7, d); chk("R8 tx drop count saturates", d, 32'(tx_drops_exp));
    rd(3'd6, d); chk("R4 tx high word", d, 32'h1357_9BDF);
    rd(3'd4, d); chk("R5 tx high read clears valid", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_capture_rx();
    t_lock();
    t_same_cycle();
    t_disabled();
    t_disable_clears();
    t_tx_indep();
    t_saturate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule